// File: doc/BRIEF.md
# Ratio-Constrained Power-of-Two Clock Enable Divider

This block derives six clock-enable strobes from a single parent clock: peripheral, display, processor, coprocessor, coprocessor memory-management and traffic-controller domains. Each domain runs at the parent rate divided by 1, 2, 4 or 8. A 2-bit exponent field in one 16-bit control word selects the divisor.

Software writes the control word. Before the word is stored, a combinational fix-up stage enforces fixed ratio rules between the domains. It brings the memory-management exponent into a window around the coprocessor exponent. It then clamps the traffic-controller exponent from below by the processor and memory-management exponents, and from above by the display and peripheral exponents. The clamps are applied in a fixed order. The corrected word is what is stored and what readback returns. Each domain counter restarts whenever its stored exponent changes, so a new ratio takes effect at a known cycle.

Top module: `clkdiv_top`

## Requirements
- R1: The control word packs six 2-bit exponents: peripheral in bits [1:0], display in [3:2], processor in [5:4], coprocessor in [7:6], memory-management in [9:8] and traffic-controller in [11:10]. `tick[i]` belongs to the field at bits [2i+1:2i] and pulses high for one cycle every 2^exp parent cycles.
- R2: A memory-management exponent written below the coprocessor exponent is stored equal to the coprocessor exponent.
- R3: A memory-management exponent written above the coprocessor exponent plus one is stored as the coprocessor exponent plus one.
- R4: The traffic-controller exponent is raised to at least the processor exponent, and then to at least the already corrected memory-management exponent.
- R5: After R4, the traffic-controller exponent is lowered to at most the display exponent, and then to at most the peripheral exponent. The peripheral bound is applied last and wins over every earlier clamp.
- R6: Bits [15:12] are stored exactly as written, and `rd_data` always shows the stored corrected word.
- R7: When a write changes a domain's exponent, that domain's `tick` is high in the cycle after the second rising edge counted from the write edge. From then on it repeats with the new period.
- R8: While `wr_en` is low, the stored word and every tick period stay unchanged, whatever is on `wr_data`.
- R9: A synchronous active-high reset clears the stored word to zero, so every `tick` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Requested control word |
| rd_data | output | 16 | Stored, corrected control word |
| tick | output | 6 | Per-domain clock-enable pulses (index order as in R1) |

## Verification
On every cycle, the embedded assertions check the invariants of the stored word: the memory-management window, the upper bounds on the traffic-controller exponent, the spare bits passing through, and the word holding while no write occurs. They also check that each counter stays within its period and never ticks twice in a row at a ratio above one. Other properties depend on the written values and the timing, and only the directed scenarios can show them. These are the order of the traffic-controller clamps (which bound wins when the bounds conflict), the exact tick counts per window for each ratio, and the cycle where a changed domain first ticks after a write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int EXP_W   = 2;
    localparam int NUM_DOM = 6;
    localparam int WORD_W  = 16;
    localparam int SPARE_W = WORD_W - NUM_DOM * EXP_W;

    typedef logic [EXP_W-1:0] exp_t;

    typedef enum logic [2:0] {
        DOM_PER  = 3'd0,
        DOM_DISP = 3'd1,
        DOM_PROC = 3'd2,
        DOM_COP  = 3'd3,
        DOM_MMU  = 3'd4,
        DOM_TC   = 3'd5
    } dom_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        exp_t               tc;
        exp_t               mmu;
        exp_t               cop;
        exp_t               proc;
        exp_t               disp;
        exp_t               per;
    } ctl_word_t;

    function automatic exp_t exp_raise(input exp_t v, input exp_t floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    function automatic exp_t exp_lower(input exp_t v, input exp_t ceil_v);
        return (v > ceil_v) ? ceil_v : v;
    endfunction

    function automatic logic exp_above_next(input exp_t v, input exp_t base);
        return ({1'b0, v} > ({1'b0, base} + 1'b1));
    endfunction

endpackage

// File: rtl/clkdiv_ratio_fix.sv
module clkdiv_ratio_fix
    import clkdiv_pkg::*;
(
    input  ctl_word_t req_i,
    output ctl_word_t fixed_o
);

    exp_t mmu_lo;
    exp_t mmu_fix;
    exp_t tc_a;
    exp_t tc_b;
    exp_t tc_c;
    exp_t tc_d;

    always_comb begin
        mmu_lo  = exp_raise(req_i.mmu, req_i.cop);
        mmu_fix = exp_above_next(mmu_lo, req_i.cop) ? exp_t'(req_i.cop + 1'b1) : mmu_lo;
        tc_a    = exp_raise(req_i.tc, req_i.proc);
        tc_b    = exp_raise(tc_a, mmu_fix);
        tc_c    = exp_lower(tc_b, req_i.disp);
        tc_d    = exp_lower(tc_c, req_i.per);
    end

    always_comb begin
        fixed_o     = req_i;
        fixed_o.mmu = mmu_fix;
        fixed_o.tc  = tc_d;
    end

endmodule

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  ctl_word_t fixed_i,
    input  ctl_word_t raw_i,
    output ctl_word_t word_o
);

    ctl_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= fixed_i;
        end
    end

    assign word_o = word_q;

    AST_MMU_FLOOR: assert property (@(posedge clk) disable iff (rst)
        word_q.mmu >= word_q.cop);                                             // R2
    AST_MMU_CEIL: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, word_q.mmu} <= ({1'b0, word_q.cop} + 3'd1)));                  // R3
    AST_TC_CEIL: assert property (@(posedge clk) disable iff (rst)
        (word_q.tc <= word_q.disp || word_q.tc <= word_q.per) && word_q.tc <= word_q.per); // R5
    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> word_q.spare == $past(raw_i.spare));                          // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word_q));                                           // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> word_q == '0);                                                  // R9

endmodule

// File: rtl/clkdiv_domain_cnt.sv
module clkdiv_domain_cnt #(
    parameter int EXP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);

    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] reload;
    logic             exp_moved;

    always_comb begin
        span      = (CNT_W + 1)'(1) << exp_i;
        reload    = CNT_W'(span - 1'b1);
        exp_moved = (exp_i != exp_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else if (exp_moved) begin
            cnt_q <= '0;
            exp_q <= exp_i;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt_q} < ((CNT_W + 1)'(1) << exp_q)));                          // R1
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !exp_moved && exp_q != '0) |=> !tick_o);                     // R1
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        exp_moved |=> tick_o);                                                  // R7

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_DOM-1:0] tick
);

    ctl_word_t req_word;
    ctl_word_t fixed_word;
    ctl_word_t stored_word;

    assign req_word = ctl_word_t'(wr_data);

    clkdiv_ratio_fix u_fix (
        .req_i   (req_word),
        .fixed_o (fixed_word)
    );

    clkdiv_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .fixed_i (fixed_word),
        .raw_i   (req_word),
        .word_o  (stored_word)
    );

    assign rd_data = WORD_W'(stored_word);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        clkdiv_domain_cnt #(.EXP_W(EXP_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .exp_i  (rd_data[d*EXP_W +: EXP_W]),
            .tick_o (tick[d])
        );
    end

endmodule

// File: tb/tb_clkdiv_top.sv
module tb_clkdiv_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [5:0]  tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_top dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .tick    (tick)
    );

    // Independent model of the correction rules (R2..R6).
    function automatic logic [15:0] model(input logic [15:0] w);
        int per, disp, proc, cop, mmu, tc;
        per  = int'(w[1:0]);   disp = int'(w[3:2]);  proc = int'(w[5:4]);
        cop  = int'(w[7:6]);   mmu  = int'(w[9:8]);  tc   = int'(w[11:10]);
        if (mmu < cop)     mmu = cop;
        if (mmu > cop + 1) mmu = cop + 1;
        if (tc < proc)     tc = proc;
        if (tc < mmu)      tc = mmu;
        if (tc > disp)     tc = disp;
        if (tc > per)      tc = per;
        return {w[15:12], 2'(tc), 2'(mmu), 2'(cop), 2'(proc), 2'(disp), 2'(per)};
    endfunction

    function automatic logic [15:0] pack(input int tc, mmu, cop, proc, disp, per,
                                         input logic [3:0] sp);
        return {sp, 2'(tc), 2'(mmu), 2'(cop), 2'(proc), 2'(disp), 2'(per)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 16'hdead;
    endtask

    // Count ticks per domain over 16 consecutive cycles; compare with 16 >> exp.
    task automatic chk_periods(input string req, input logic [15:0] w);
        int cnt [6];
        for (int d = 0; d < 6; d++) cnt[d] = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++) if (tick[d]) cnt[d]++;
        end
        for (int d = 0; d < 6; d++)
            chk(req, 32'(cnt[d]), 32'(16 >> w[2*d +: 2]));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 word cleared", 32'(rd_data), 32'h0);
        chk("R9 ticks every cycle", 32'(tick), 32'h3f);
        @(negedge clk);
        chk("R9 ticks every cycle next", 32'(tick), 32'h3f);
    endtask

    task automatic t_ratio_and_restart;
        logic [15:0] w;
        w = pack(3, 2, 2, 1, 3, 3, 4'h0);
        do_write(w);
        chk("R6 readback", 32'(rd_data), 32'(model(w)));
        @(negedge clk);
        chk("R7 changed domains tick", 32'(tick), 32'h3f);
        chk_periods("R1 periods", rd_data);
    endtask

    task automatic t_mmu_clamps;
        logic [15:0] w;
        w = pack(3, 0, 3, 0, 3, 3, 4'h0);
        do_write(w);
        chk("R2 mmu raised", 32'(rd_data[9:8]), 32'd3);
        chk("R2 word", 32'(rd_data), 32'(model(w)));
        w = pack(3, 3, 0, 0, 3, 3, 4'h0);
        do_write(w);
        chk("R3 mmu lowered", 32'(rd_data[9:8]), 32'd1);
        chk("R3 word", 32'(rd_data), 32'(model(w)));
    endtask

    task automatic t_tc_clamps;
        logic [15:0] w;
        w = pack(0, 0, 0, 2, 3, 3, 4'h0);
        do_write(w);
        chk("R4 tc raised by proc", 32'(rd_data[11:10]), 32'd2);
        w = pack(0, 3, 2, 0, 3, 3, 4'h0);
        do_write(w);
        chk("R4 tc raised by mmu", 32'(rd_data[11:10]), 32'd3);
        w = pack(3, 0, 0, 0, 1, 3, 4'h0);
        do_write(w);
        chk("R5 tc lowered by disp", 32'(rd_data[11:10]), 32'd1);
        w = pack(0, 3, 2, 3, 3, 0, 4'h0);
        do_write(w);
        chk("R5 per bound wins", 32'(rd_data[11:10]), 32'd0);
        chk("R5 word", 32'(rd_data), 32'(model(w)));
        chk_periods("R1 periods after clamp", rd_data);
    endtask

    task automatic t_spare_and_hold;
        logic [15:0] w;
        logic [15:0] held;
        w = pack(1, 1, 0, 1, 2, 3, 4'ha);
        do_write(w);
        chk("R6 spare bits", 32'(rd_data[15:12]), 32'ha);
        chk("R6 word", 32'(rd_data), 32'(model(w)));
        held = rd_data;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            wr_data = 16'(c * 16'h1357);
        end
        chk("R8 word held", 32'(rd_data), 32'(held));
        chk_periods("R8 periods held", held);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears", 32'(rd_data), 32'h0);
        chk("R9 ticks after reset", 32'(tick), 32'h3f);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_data = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratio_and_restart();
        t_mmu_clamps();
        t_tc_clamps();
        t_spare_and_hold();
        t_reset_again();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule